// File: doc/BRIEF.md
# Nine-Bit Panel Command Transmitter

This block is a write-only serial master for the control port of a display panel controller. The host hands it one request at a time through a valid/ready handshake. A request carries a register or command byte and a payload kind. The block then sends one command word, followed by zero, one or two data words, under a single chip-select window, and pulses `done` when the window has closed.

Every serial word is nine bits wide. Its top bit tells the panel whether the remaining byte is a command or data. Because the panel has no output line, nothing is ever read back over the wire. Instead, the block keeps a local shadow copy of the last value written to each register, and the host can read that copy at any time through a combinational read port. The serial clock is produced by dividing the system clock with a parameter, and the bus runs in SPI mode 3.

Top module: `n9_panel_cmd_tx`

## Requirements
- R1: Each serial word is 9 bits, shifted out MSB first (bit 8 first). Bit 8 is 0 for the command word and 1 for every data word, and bits 7:0 carry the byte.
- R2: `req_kind` selects the transaction shape. A value of 0 sends the command word only (9 bits). A value of 1 adds one data word holding `req_data[7:0]` (18 bits). A value of 2 adds two data words holding `req_data[15:0]` (27 bits). The reserved value 3 behaves exactly like 0.
- R3: A 16-bit payload is sent high byte (`req_data[15:8]`) first, then low byte, each byte in its own data word.
- R4: SPI mode 3 applies. `spi_sclk` is high whenever `spi_cs_n` is high. `spi_mosi` changes only on falling edges of `spi_sclk` and is stable while `spi_sclk` is high inside a transaction.
- R5: `spi_cs_n` stays low without a break across all words of one transaction. After it rises, it stays high for at least 2*DIV_HALF system clock cycles before it can fall again.
- R6: Every `spi_sclk` half-period lasts DIV_HALF system clock cycles. This includes the interval from the fall of `spi_cs_n` to the first falling edge.
- R7: `req_ready` is high only while the block is idle. A request is taken only in a cycle with both `req_valid` and `req_ready` high. `req_valid` raised while `req_ready` is low starts nothing.
- R8: `done` is a single-cycle pulse, raised once per transaction at the end of the chip-select gap. `req_ready` is high in that same cycle.
- R9: The shadow entry for the request address is written at the `done` edge. It reads the old value up to and including the `done` cycle, and the new value from the next cycle on. The value written depends on the kind: 0 for kinds 0 and 3, `{8'h00, req_data[7:0]}` for kind 1, and `req_data` for kind 2.
- R10: Only addresses 0 to SHADOW_DEPTH-1 are shadowed (0x00 to 0xED by default). A request to a higher address is still transmitted but is not stored, and reading such an address returns 0.
- R11: After reset, `spi_cs_n`=1, `spi_sclk`=1, `spi_mosi`=0, `done`=0, `req_ready`=1, and every shadow entry reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 8 | Register / command byte |
| req_kind | input | 2 | Payload kind: 0 none, 1 byte, 2 sixteen-bit, 3 reserved (none) |
| req_data | input | 16 | Payload value |
| done | output | 1 | One-cycle pulse at transaction end |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| shadow_raddr | input | 8 | Shadow read address |
| shadow_rdata | output | 16 | Shadow value at `shadow_raddr` |

## Verification
Two things can fall in the same cycle: the shadow update at the end of a transaction, and a host read of that same register. The bench keeps the read address on the register being written throughout every request. In the cycle where `done` is seen, it expects the old value from its own model. One cycle later, it expects the new value. A stray `req_valid` raised during a busy window has to leave both the serial stream and the shadow unchanged, and the scoreboard catches any unexpected frame.

// File: rtl/n9tx_pkg.sv
package n9tx_pkg;

  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int MAX_WORDS = 3;
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int VAL_W     = 2 * BYTE_W;
  localparam int NBITS_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_BYTE = 2'd1,
    PK_HALF = 2'd2,
    PK_RSVD = 2'd3
  } payload_kind_e;

  // number of 9-bit words a request of this kind produces
  function automatic int unsigned words_for(logic [1:0] kind);
    case (kind)
      PK_BYTE: return 2;
      PK_HALF: return 3;
      default: return 1;
    endcase
  endfunction

  // left-aligned frame: command word in the top slot
  function automatic logic [FRAME_W-1:0] build_frame(logic [BYTE_W-1:0] addr,
                                                     logic [1:0]        kind,
                                                     logic [VAL_W-1:0]  data);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[FRAME_W-1 -: WORD_W] = {1'b0, addr};
    if (kind == PK_BYTE) begin
      f[FRAME_W-WORD_W-1 -: WORD_W] = {1'b1, data[BYTE_W-1:0]};
    end else if (kind == PK_HALF) begin
      f[FRAME_W-WORD_W-1 -: WORD_W]   = {1'b1, data[VAL_W-1:BYTE_W]};
      f[FRAME_W-2*WORD_W-1 -: WORD_W] = {1'b1, data[BYTE_W-1:0]};
    end
    return f;
  endfunction

  // value the shadow copy takes after the transaction
  function automatic logic [VAL_W-1:0] shadow_value(logic [1:0] kind, logic [VAL_W-1:0] data);
    case (kind)
      PK_BYTE: return {{BYTE_W{1'b0}}, data[BYTE_W-1:0]};
      PK_HALF: return data;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/n9tx_half_tick.sv
module n9tx_half_tick #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LIM = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!en || cnt == LIM)  cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LIM);
endmodule

// File: rtl/n9tx_serializer.sv
module n9tx_serializer
  import n9tx_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [NBITS_W-1:0] nbits_in,
  output logic               busy,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               done
);
  localparam int GAP_MIN = 2 * DIV_HALF;
  localparam int HW      = $clog2(GAP_MIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL, S_GAP} ser_state_e;

  ser_state_e         state;
  logic [FRAME_W-1:0] sh;
  logic [NBITS_W-1:0] bits_left;
  logic               sclk_q, cs_q, mosi_q, done_q, gap_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sh        <= '0;
      bits_left <= '0;
      sclk_q    <= 1'b1;
      cs_q      <= 1'b1;
      mosi_q    <= 1'b0;
      done_q    <= 1'b0;
      gap_half  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          sh        <= frame_in;
          bits_left <= nbits_in;
          cs_q      <= 1'b0;
          state     <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            mosi_q <= sh[FRAME_W-1];
            sh     <= sh << 1;
          end else begin
            sclk_q <= 1'b1;
            if (bits_left == NBITS_W'(1)) state <= S_TAIL;
            else                          bits_left <= bits_left - 1'b1;
          end
        end
        S_TAIL: if (tick) begin
          cs_q     <= 1'b1;
          gap_half <= 1'b0;
          state    <= S_GAP;
        end
        default: if (tick) begin
          if (gap_half) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            gap_half <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = mosi_q;
  assign done = done_q;

  // verification events
  logic           sclk_rise_ev;
  logic [NBITS_W-1:0] rise_cnt;
  logic [HW-1:0]  hi_cnt;
  assign sclk_rise_ev = (state == S_SHIFT) && tick && !sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      hi_cnt   <= HW'(GAP_MIN);
    end else begin
      if (start && !busy)    rise_cnt <= '0;
      else if (sclk_rise_ev) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_q)                      hi_cnt <= '0;
      else if (hi_cnt != HW'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R4
  cs_idle_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);
  // R4
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && $past(!cs_q) && sclk_q) |-> $stable(mosi_q));
  // R5
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (hi_cnt >= HW'(GAP_MIN)));
  // R2
  word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> (rise_cnt == NBITS_W'(WORD_W) || rise_cnt == NBITS_W'(2*WORD_W)
                     || rise_cnt == NBITS_W'(3*WORD_W)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/n9tx_shadow.sv
module n9tx_shadow #(
  parameter int DEPTH  = 238,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic w_in_range, r_in_range;

  assign w_in_range = ({1'b0, waddr} < DEPTH_V);
  assign r_in_range = ({1'b0, raddr} < DEPTH_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && w_in_range) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = r_in_range ? mem[raddr] : '0;
endmodule

// File: rtl/n9_panel_cmd_tx.sv
module n9_panel_cmd_tx
  import n9tx_pkg::*;
#(
  parameter int DIV_HALF     = 4,
  parameter int SHADOW_DEPTH = 238
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_data,
  output logic        done,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic [7:0]  shadow_raddr,
  output logic [15:0] shadow_rdata
);
  logic               busy, tick, accept;
  logic [NBITS_W-1:0] nbits;
  logic [FRAME_W-1:0] frame;
  logic [BYTE_W-1:0]  lat_addr;
  logic [VAL_W-1:0]   lat_val;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign nbits     = NBITS_W'(WORD_W * words_for(req_kind));
  assign frame     = build_frame(req_addr, req_kind, req_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_val  <= '0;
    end else if (accept) begin
      lat_addr <= req_addr;
      lat_val  <= shadow_value(req_kind, req_data);
    end
  end

  n9tx_half_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  n9tx_serializer #(.DIV_HALF(DIV_HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(accept),
    .frame_in(frame), .nbits_in(nbits), .busy(busy),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .done(done)
  );

  n9tx_shadow #(.DEPTH(SHADOW_DEPTH), .ADDR_W(BYTE_W), .DATA_W(VAL_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(done), .waddr(lat_addr), .wdata(lat_val),
    .raddr(shadow_raddr), .rdata(shadow_rdata)
  );

  // R8
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  // R7
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);
endmodule

// File: tb/tb_n9_panel_cmd_tx.sv
module tb_n9_panel_cmd_tx;
  localparam int DIV   = 3;
  localparam int DEPTH = 238;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_data = '0;
  logic        done, spi_sclk, spi_cs_n, spi_mosi;
  logic [7:0]  shadow_raddr = '0;
  logic [15:0] shadow_rdata;

  always #5 clk = ~clk;

  n9_panel_cmd_tx #(.DIV_HALF(DIV), .SHADOW_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_data(req_data), .done(done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .shadow_raddr(shadow_raddr), .shadow_rdata(shadow_rdata)
  );

  typedef struct { logic [26:0] bits; int n; } frame_t;
  frame_t      exp_q[$];
  logic [15:0] model [256];
  int checks = 0, errors = 0, n_sent = 0, n_done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: push expected frame, handshake, then judge the shadow around done
  task automatic send(logic [7:0] a, logic [1:0] k, logic [15:0] d, int stray_cycles);
    frame_t f;
    logic [15:0] newv;
    case (k)
      2'd1:    begin f.bits = {9'b0, 1'b0, a, 1'b1, d[7:0]}; f.n = 18; newv = {8'h00, d[7:0]}; end
      2'd2:    begin f.bits = {1'b0, a, 1'b1, d[15:8], 1'b1, d[7:0]}; f.n = 27; newv = d; end
      default: begin f.bits = {18'b0, 1'b0, a}; f.n = 9; newv = 16'h0000; end
    endcase
    exp_q.push_back(f);
    shadow_raddr = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    n_sent++;
    chk(req_ready == 1'b0, "R7", "ready low while busy", req_ready, 0);
    if (stray_cycles > 0) begin
      req_valid = 1'b1; req_addr = 8'h55; req_kind = 2'd2; req_data = 16'hDEAD;
      repeat (stray_cycles) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) begin
      chk(shadow_rdata == ((a < DEPTH) ? model[a] : 16'h0), "R9", "old value before done",
          shadow_rdata, model[a]);
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R8", "ready with done", req_ready, 1);
    chk(shadow_rdata == ((a < DEPTH) ? model[a] : 16'h0), "R9", "old value in done cycle",
        shadow_rdata, model[a]);
    if (a < DEPTH) model[a] = newv;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
    chk(shadow_rdata == ((a < DEPTH) ? newv : 16'h0), "R9/R10", "value after done",
        shadow_rdata, (a < DEPTH) ? newv : 16'h0);
  endtask

  // monitor: serial receiver and timing judge, all sampled at the falling clk edge
  logic        prev_cs = 1'b1, prev_sclk = 1'b1, prev_done = 1'b0, have_rise = 1'b0;
  int          cyc = 0, last_edge = 0, cs_rise = 0, rx_n = 0;
  logic [26:0] rx = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done) n_done++;
      if (done && prev_done) chk(0, "R8", "done wider than one cycle", 1, 0);
      if (prev_cs && !spi_cs_n) begin
        chk(spi_sclk == 1'b1, "R4", "sclk high at cs fall", spi_sclk, 1);
        if (have_rise) chk(cyc - cs_rise >= 2*DIV, "R5", "cs high gap", cyc - cs_rise, 2*DIV);
        last_edge = cyc; rx_n = 0; rx = '0;
      end
      if (!spi_cs_n && spi_sclk != prev_sclk) begin
        chk(cyc - last_edge == DIV, "R6", "sclk half period", cyc - last_edge, DIV);
        last_edge = cyc;
        if (spi_sclk) begin rx = {rx[25:0], spi_mosi}; rx_n++; end
      end
      if (spi_cs_n && spi_sclk != prev_sclk) chk(0, "R4", "sclk moved while cs high", spi_sclk, prev_sclk);
      if (!prev_cs && spi_cs_n) begin
        chk(spi_sclk == 1'b1, "R4", "sclk high at cs rise", spi_sclk, 1);
        if (exp_q.size() == 0) chk(0, "R7", "unexpected frame", rx, 0);
        else begin
          frame_t f;
          f = exp_q.pop_front();
          chk(rx_n == f.n, "R2/R5", "bits in one cs window", rx_n, f.n);
          chk(rx == f.bits, "R1/R3", "frame content", rx, f.bits);
        end
        cs_rise = cyc; have_rise = 1'b1;
      end
    end
    prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_done = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(spi_cs_n == 1'b1, "R11", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R11", "sclk after reset", spi_sclk, 1);
    chk(spi_mosi == 1'b0, "R11", "mosi after reset", spi_mosi, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    shadow_raddr = 8'hB6; #1;
    chk(shadow_rdata == 16'h0, "R11", "shadow after reset", shadow_rdata, 0);

    send(8'h11, 2'd0, 16'hFFFF, 0);   // R2 command only
    send(8'h3A, 2'd1, 16'hAB60, 0);   // R2 one byte
    send(8'hB8, 2'd2, 16'hFFF9, 0);   // R3 sixteen-bit, high first
    send(8'hC3, 2'd2, 16'h2040, 0);
    send(8'h29, 2'd1, 16'h00A5, 0);
    send(8'h29, 2'd3, 16'h1234, 0);   // R2 reserved kind, shadow back to zero
    send(8'hB8, 2'd0, 16'h0000, 0);   // R9 command only clears a set entry
    send(8'hED, 2'd2, 16'h8001, 0);   // R10 last shadowed address
    send(8'hEE, 2'd2, 16'h5AA5, 0);   // R10 first unshadowed address
    send(8'hFF, 2'd1, 16'h00C3, 0);
    send(8'h00, 2'd2, 16'h0100, 20);  // R7 stray valid while busy
    send(8'hB0, 2'd1, 16'h0017, 0);

    shadow_raddr = 8'h55; #1;
    chk(shadow_rdata == 16'h0, "R7", "stray request not stored", shadow_rdata, 0);
    shadow_raddr = 8'hC3; #1;
    chk(shadow_rdata == 16'h2040, "R9", "earlier entry kept", shadow_rdata, 16'h2040);
    repeat (4*DIV) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all frames seen", exp_q.size(), 0);
    chk(n_done == n_sent, "R8", "one done per request", n_done, n_sent);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule